// File: doc/BRIEF.md
# Dual-Channel Converter Strobe Sequencer

This block sits between on-chip logic and an external dual-channel converter. The converter has one ADC and two DAC channels behind a shared parallel data bus. The converter is controlled by active-low chip-select, write and read strobes, plus a converter-select line and a channel-select line, and it reports a finished conversion on an active-low interrupt line. Internal logic issues one of three commands on a simple request port: begin a conversion on a channel, fetch the last conversion result, or load a code into a DAC channel. The block then produces the strobe sequence with every pulse width, setup, hold and wait counted in system clock cycles.

Each timing minimum is given to the block in nanoseconds together with the clock period. The block turns each one into a cycle count, rounded up and never less than one. The interrupt line is synchronised before use. A conversion that never signals completion is cut short by a timeout. The data bus is modelled as separate drive, enable and input signals, and the block drives it only while a DAC code is being loaded.

Top module: `cvt_bus_ctrl`

## Requirements
- R1: Whenever `wr_n` is low, `cs_n` is also low, and `sel_dac` and `chan_sel` do not change until `wr_n` has returned high.
- R2: Every write strobe stays low for exactly WR_CYC cycles. WR_CYC is the larger of ceil(WR_PULSE_NS/CLK_PERIOD_NS) and ceil(DATA_SETUP_NS/CLK_PERIOD_NS), which is 8 with the default parameters.
- R3: A request with `req_cmd` = 2'b01 (conversion) gives one write strobe with `sel_dac` = 0 and `chan_sel` = `req_chan`. Once the synchronised `int_n` is seen low, the block gives a `done` pulse with `timeout_err` = 0.
- R4: For BLANK_CYC cycles after the conversion write strobe rises, a low `int_n` is ignored. BLANK_CYC is ceil(INT_CLEAR_NS/period) plus the synchroniser depth, which is 11 by default. This means a low level left over from an earlier, unread conversion does not complete the new one.
- R5: If `int_n` has not been seen low within TO_CYC cycles of the write strobe rising (320 by default), the block gives `done` and sets `timeout_err`. The flag stays set until the next request is accepted.
- R6: A request with `req_cmd` = 2'b10 (read) pulls `cs_n` and `rd_n` low together for RD_CYC cycles (7 by default). The block samples `bus_in` into `rdata` on the edge where `rd_n` rises, and gives `done` only after a further REL_CYC cycles (7 by default) for the bus to be released.
- R7: A request with `req_cmd` = 2'b11 (DAC load) sets `sel_dac` = 1 and holds `bus_oe` = 1 with `bus_out` = `req_wdata`, unchanged, from the fall of `wr_n` until HOLD_CYC cycles after its rise (2 by default).
- R8: After a DAC load, `done` comes no earlier than SETTLE_CYC cycles after the hold interval ends (400 by default).
- R9: `bus_oe` is low in every phase except a DAC load, and it is never high while `rd_n` is low.
- R10: `req_ready` is high only while idle. A request presented while `req_ready` is low is ignored, and `req_cmd` = 2'b00 is ignored even when idle.
- R11: `done` is a single-cycle pulse, given exactly once for each accepted request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_cmd | input | 2 | 01 convert, 10 read, 11 DAC load, 00 no operation |
| req_chan | input | 1 | Target channel |
| req_wdata | input | DW | DAC code for a load request |
| req_ready | output | 1 | High when idle and able to accept a request |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DW | Last sampled conversion result |
| timeout_err | output | 1 | Last conversion timed out |
| cs_n | output | 1 | Converter chip select, active low |
| wr_n | output | 1 | Write strobe, active low |
| rd_n | output | 1 | Read strobe, active low |
| sel_dac | output | 1 | 1 selects the DAC, 0 selects the ADC |
| chan_sel | output | 1 | Channel select |
| int_n | input | 1 | Conversion-complete flag from the converter, active low, asynchronous |
| bus_in | input | DW | Data bus as seen by the host |
| bus_out | output | DW | Data the host drives onto the bus |
| bus_oe | output | 1 | Host bus drive enable |

## Verification
The bound checker watches the strobe relationships on every cycle. These are chip select covering each write and read strobe, the selects held across a write strobe, the minimum write strobe width, bus drive limited to DAC loads with steady data, the quiet idle bus and the single-cycle done pulse. Some properties cannot be seen from one cycle of strobes and need the bench's converter model. These are the right result sampled at the end of the read window, the stale interrupt being ignored, the timeout and when its flag clears, the settling wait, and busy or no-operation requests having no effect.

// File: rtl/cvt_bus_pkg.sv
package cvt_bus_pkg;

    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_CONV  = 2'b01,
        CMD_READ  = 2'b10,
        CMD_WRITE = 2'b11
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CV_WR,
        ST_CV_WAIT,
        ST_RD_LOW,
        ST_RD_REL,
        ST_DA_WR,
        ST_DA_HOLD,
        ST_DA_SETTLE
    } state_e;

    // Round a time up to whole clock cycles, at least one.
    function automatic int ns_to_cyc(input int ns, input int period_ns);
        int c;
        c = (ns + period_ns - 1) / period_ns;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/cvt_sync.sv
module cvt_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
        else        chain_q <= {chain_q[STAGES-2:0], d};
    end

    assign q = chain_q[STAGES-1];
endmodule

// File: rtl/cvt_cycle_timer.sv
module cvt_cycle_timer #(
    parameter int TW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (load)               cnt_d = load_val;
        else if (cnt_q != '0)   cnt_d = cnt_q - 1'b1;
        else                    cnt_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/cvt_bus_ctrl.sv
module cvt_bus_ctrl
    import cvt_bus_pkg::*;
#(
    parameter int DW              = 8,
    parameter int CLK_PERIOD_NS   = 10,
    parameter int WR_PULSE_NS     = 80,
    parameter int DATA_SETUP_NS   = 65,
    parameter int DATA_HOLD_NS    = 15,
    parameter int RD_ACCESS_NS    = 65,
    parameter int BUS_RELEASE_NS  = 65,
    parameter int INT_CLEAR_NS    = 85,
    parameter int SETTLE_NS       = 4000,
    parameter int CONV_TIMEOUT_NS = 3200,
    parameter int SYNC_STAGES     = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [1:0]    req_cmd,
    input  logic          req_chan,
    input  logic [DW-1:0] req_wdata,
    output logic          req_ready,
    output logic          done,
    output logic [DW-1:0] rdata,
    output logic          timeout_err,
    output logic          cs_n,
    output logic          wr_n,
    output logic          rd_n,
    output logic          sel_dac,
    output logic          chan_sel,
    input  logic          int_n,
    input  logic [DW-1:0] bus_in,
    output logic [DW-1:0] bus_out,
    output logic          bus_oe
);
    localparam int WR_CYC     = (ns_to_cyc(WR_PULSE_NS, CLK_PERIOD_NS) > ns_to_cyc(DATA_SETUP_NS, CLK_PERIOD_NS))
                              ? ns_to_cyc(WR_PULSE_NS, CLK_PERIOD_NS) : ns_to_cyc(DATA_SETUP_NS, CLK_PERIOD_NS);
    localparam int HOLD_CYC   = ns_to_cyc(DATA_HOLD_NS, CLK_PERIOD_NS);
    localparam int RD_CYC     = ns_to_cyc(RD_ACCESS_NS, CLK_PERIOD_NS);
    localparam int REL_CYC    = ns_to_cyc(BUS_RELEASE_NS, CLK_PERIOD_NS);
    localparam int SETTLE_CYC = ns_to_cyc(SETTLE_NS, CLK_PERIOD_NS);
    localparam int TO_CYC     = ns_to_cyc(CONV_TIMEOUT_NS, CLK_PERIOD_NS);
    localparam int BLANK_CYC  = ns_to_cyc(INT_CLEAR_NS, CLK_PERIOD_NS) + SYNC_STAGES;
    localparam int MAX_A      = (SETTLE_CYC > TO_CYC) ? SETTLE_CYC : TO_CYC;
    localparam int MAX_B      = (WR_CYC > RD_CYC) ? WR_CYC : RD_CYC;
    localparam int MAX_CYC    = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TW         = $clog2(MAX_CYC + 1);
    localparam int BW         = $clog2(BLANK_CYC + 1);

    typedef struct packed {
        state_e        state;
        logic          chan;
        logic [DW-1:0] wdata;
        logic          sel_dac;
        logic          cs_n;
        logic          wr_n;
        logic          rd_n;
        logic          oe;
        logic          done;
        logic          err;
        logic [DW-1:0] rdata;
        logic [BW-1:0] blank;
    } ctrl_t;

    localparam ctrl_t CTRL_RST = '{
        state: ST_IDLE, chan: 1'b0, wdata: '0, sel_dac: 1'b0,
        cs_n: 1'b1, wr_n: 1'b1, rd_n: 1'b1, oe: 1'b0,
        done: 1'b0, err: 1'b0, rdata: '0, blank: '0
    };

    ctrl_t         ctrl_d, ctrl_q;
    logic          int_s;
    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_expired;

    cvt_sync #(
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (1'b1)
    ) u_int_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (int_n),
        .q     (int_s)
    );

    cvt_cycle_timer #(
        .TW (TW)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    always_comb begin
        ctrl_d      = ctrl_q;
        ctrl_d.done = 1'b0;
        tmr_load    = 1'b0;
        tmr_val     = '0;

        unique case (ctrl_q.state)
            ST_IDLE: begin
                if (req_valid && (cmd_e'(req_cmd) != CMD_NOP)) begin
                    ctrl_d.chan  = req_chan;
                    ctrl_d.wdata = req_wdata;
                    ctrl_d.err   = 1'b0;
                    ctrl_d.cs_n  = 1'b0;
                    tmr_load     = 1'b1;
                    unique case (cmd_e'(req_cmd))
                        CMD_CONV: begin
                            ctrl_d.state   = ST_CV_WR;
                            ctrl_d.sel_dac = 1'b0;
                            ctrl_d.wr_n    = 1'b0;
                            tmr_val        = TW'(WR_CYC - 1);
                        end
                        CMD_READ: begin
                            ctrl_d.state   = ST_RD_LOW;
                            ctrl_d.sel_dac = 1'b0;
                            ctrl_d.rd_n    = 1'b0;
                            tmr_val        = TW'(RD_CYC - 1);
                        end
                        default: begin
                            ctrl_d.state   = ST_DA_WR;
                            ctrl_d.sel_dac = 1'b1;
                            ctrl_d.wr_n    = 1'b0;
                            ctrl_d.oe      = 1'b1;
                            tmr_val        = TW'(WR_CYC - 1);
                        end
                    endcase
                end
            end

            ST_CV_WR: begin
                if (tmr_expired) begin
                    ctrl_d.cs_n  = 1'b1;
                    ctrl_d.wr_n  = 1'b1;
                    ctrl_d.blank = BW'(BLANK_CYC);
                    ctrl_d.state = ST_CV_WAIT;
                    tmr_load     = 1'b1;
                    tmr_val      = TW'(TO_CYC - 1);
                end
            end

            ST_CV_WAIT: begin
                if (ctrl_q.blank != '0) begin
                    ctrl_d.blank = ctrl_q.blank - 1'b1;
                end
                if ((ctrl_q.blank == '0) && !int_s) begin
                    ctrl_d.done  = 1'b1;
                    ctrl_d.state = ST_IDLE;
                end else if (tmr_expired) begin
                    ctrl_d.err   = 1'b1;
                    ctrl_d.done  = 1'b1;
                    ctrl_d.state = ST_IDLE;
                end
            end

            ST_RD_LOW: begin
                if (tmr_expired) begin
                    ctrl_d.cs_n  = 1'b1;
                    ctrl_d.rd_n  = 1'b1;
                    ctrl_d.rdata = bus_in;
                    ctrl_d.state = ST_RD_REL;
                    tmr_load     = 1'b1;
                    tmr_val      = TW'(REL_CYC - 1);
                end
            end

            ST_RD_REL: begin
                if (tmr_expired) begin
                    ctrl_d.done  = 1'b1;
                    ctrl_d.state = ST_IDLE;
                end
            end

            ST_DA_WR: begin
                if (tmr_expired) begin
                    ctrl_d.cs_n  = 1'b1;
                    ctrl_d.wr_n  = 1'b1;
                    ctrl_d.state = ST_DA_HOLD;
                    tmr_load     = 1'b1;
                    tmr_val      = TW'(HOLD_CYC - 1);
                end
            end

            ST_DA_HOLD: begin
                if (tmr_expired) begin
                    ctrl_d.oe    = 1'b0;
                    ctrl_d.state = ST_DA_SETTLE;
                    tmr_load     = 1'b1;
                    tmr_val      = TW'(SETTLE_CYC - 1);
                end
            end

            ST_DA_SETTLE: begin
                if (tmr_expired) begin
                    ctrl_d.done  = 1'b1;
                    ctrl_d.state = ST_IDLE;
                end
            end

            default: ctrl_d = CTRL_RST;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= CTRL_RST;
        else        ctrl_q <= ctrl_d;
    end

    assign req_ready   = (ctrl_q.state == ST_IDLE);
    assign done        = ctrl_q.done;
    assign rdata       = ctrl_q.rdata;
    assign timeout_err = ctrl_q.err;
    assign cs_n        = ctrl_q.cs_n;
    assign wr_n        = ctrl_q.wr_n;
    assign rd_n        = ctrl_q.rd_n;
    assign sel_dac     = ctrl_q.sel_dac;
    assign chan_sel    = ctrl_q.chan;
    assign bus_out     = ctrl_q.wdata;
    assign bus_oe      = ctrl_q.oe;
endmodule

// File: rtl/cvt_bus_ctrl_chk.sv
module cvt_bus_ctrl_chk #(
    parameter int DW     = 8,
    parameter int WR_CYC = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_ready,
    input logic          done,
    input logic          cs_n,
    input logic          wr_n,
    input logic          rd_n,
    input logic          sel_dac,
    input logic          chan_sel,
    input logic [DW-1:0] bus_out,
    input logic          bus_oe
);
    logic [15:0] wr_low_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    wr_low_cnt <= '0;
        else if (!wr_n && !(&wr_low_cnt)) wr_low_cnt <= wr_low_cnt + 1'b1;
        else if (wr_n)                 wr_low_cnt <= '0;
    end

    AST_WR_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> !cs_n); // R1
    AST_SEL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && $past(!wr_n)) |-> ($stable(sel_dac) && $stable(chan_sel))); // R1
    AST_WR_MIN_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> (wr_low_cnt >= 16'(WR_CYC))); // R2
    AST_RD_NEEDS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !cs_n); // R6
    AST_OE_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe && $past(bus_oe)) |-> $stable(bus_out)); // R7
    AST_OE_ONLY_DAC: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> sel_dac); // R9
    AST_OE_NOT_WITH_RD: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_oe && !rd_n)); // R9
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (cs_n && wr_n && rd_n && !bus_oe)); // R10
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R11
endmodule

bind cvt_bus_ctrl cvt_bus_ctrl_chk #(
    .DW     (DW),
    .WR_CYC (WR_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .done      (done),
    .cs_n      (cs_n),
    .wr_n      (wr_n),
    .rd_n      (rd_n),
    .sel_dac   (sel_dac),
    .chan_sel  (chan_sel),
    .bus_out   (bus_out),
    .bus_oe    (bus_oe)
);

// File: tb/test_cvt_bus_ctrl.sv
module test_cvt_bus_ctrl;
    localparam int CLK_NS     = 10;
    localparam int DW         = 8;
    localparam int WR_CYC     = 8;
    localparam int SETUP_CYC  = 7;
    localparam int HOLD_CYC   = 2;
    localparam int RD_CYC     = 7;
    localparam int REL_CYC    = 7;
    localparam int SETTLE_CYC = 400;
    localparam int TO_CYC     = 320;
    localparam logic [7:0] JUNK = 8'h5A;

    typedef struct packed {
        logic [1:0]  cmd;
        logic        ch;
        logic [7:0]  data;
        logic [15:0] dly;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{cmd: 2'd1, ch: 1'b0, data: 8'hA3, dly: 16'd20},
        '{cmd: 2'd2, ch: 1'b0, data: 8'hA3, dly: 16'd0},
        '{cmd: 2'd1, ch: 1'b1, data: 8'h3C, dly: 16'd60},
        '{cmd: 2'd2, ch: 1'b1, data: 8'h3C, dly: 16'd0},
        '{cmd: 2'd3, ch: 1'b0, data: 8'h81, dly: 16'd0},
        '{cmd: 2'd3, ch: 1'b1, data: 8'h7E, dly: 16'd0},
        '{cmd: 2'd1, ch: 1'b0, data: 8'h11, dly: 16'd150},
        '{cmd: 2'd2, ch: 1'b0, data: 8'h11, dly: 16'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_cmd = 2'b00;
    logic          req_chan = 1'b0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, done, timeout_err;
    logic [DW-1:0] rdata, bus_out, bus_in;
    logic          cs_n, wr_n, rd_n, sel_dac, chan_sel, bus_oe;
    logic          int_n;

    int compared = 0;
    int mismatched = 0;

    // converter model state
    int        cyc = 0;
    int        conv_delay = 0;
    logic [7:0] next_adc = '0;
    logic [7:0] adc_res;
    logic [7:0] dac_val [2];
    logic      wr_q, rd_q, oe_q, hold_track;
    int        wr_len, last_wr_len, rd_len, last_rd_len, stable_cnt, last_setup, hold_cnt;
    int        conv_cnt, raise_cnt, dac_writes, conv_count, oe_viol;
    int        wr_rise_cyc, rd_rise_cyc, done_cyc, done_cnt;
    logic [7:0] prev_out;
    logic      last_wr_dac, last_wr_chan;

    always #(CLK_NS/2) clk = ~clk;

    cvt_bus_ctrl i_cvt_bus_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_chan(req_chan), .req_wdata(req_wdata), .req_ready(req_ready),
        .done(done), .rdata(rdata), .timeout_err(timeout_err), .cs_n(cs_n),
        .wr_n(wr_n), .rd_n(rd_n), .sel_dac(sel_dac), .chan_sel(chan_sel),
        .int_n(int_n), .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            int_n <= 1'b1; bus_in <= JUNK; adc_res <= '0;
            dac_val[0] <= '0; dac_val[1] <= '0;
            wr_q <= 1'b1; rd_q <= 1'b1; oe_q <= 1'b0; hold_track <= 1'b0;
            wr_len <= 0; last_wr_len <= 0; rd_len <= 0; last_rd_len <= 0;
            stable_cnt <= 0; last_setup <= 0; hold_cnt <= 0; prev_out <= '0;
            conv_cnt <= 0; raise_cnt <= 0; dac_writes <= 0; conv_count <= 0;
            oe_viol <= 0; wr_rise_cyc <= 0; rd_rise_cyc <= 0; done_cyc <= 0;
            done_cnt <= 0; last_wr_dac <= 1'b0; last_wr_chan <= 1'b0;
        end else begin
            wr_q <= wr_n; rd_q <= rd_n; oe_q <= bus_oe; prev_out <= bus_out;
            if (bus_oe && !rd_n) oe_viol <= oe_viol + 1;
            if (!oe_q || !bus_oe || bus_out != prev_out) stable_cnt <= 0;
            else stable_cnt <= stable_cnt + 1;
            if (!wr_n) wr_len <= wr_len + 1;
            if (hold_track) begin
                if (bus_oe) hold_cnt <= hold_cnt + 1;
                else hold_track <= 1'b0;
            end
            if (raise_cnt == 1) int_n <= 1'b1;
            if (raise_cnt != 0) raise_cnt <= raise_cnt - 1;
            if (conv_cnt == 1) begin int_n <= 1'b0; adc_res <= next_adc; end
            if (conv_cnt != 0) conv_cnt <= conv_cnt - 1;
            if (!wr_q && wr_n) begin
                last_wr_len <= wr_len; wr_len <= 0; wr_rise_cyc <= cyc;
                last_wr_dac <= sel_dac; last_wr_chan <= chan_sel;
                if (sel_dac) begin
                    dac_val[chan_sel] <= bus_out; dac_writes <= dac_writes + 1;
                    last_setup <= stable_cnt; hold_cnt <= bus_oe ? 1 : 0; hold_track <= bus_oe;
                end else begin
                    conv_cnt <= conv_delay; raise_cnt <= 3; conv_count <= conv_count + 1;
                end
            end
            if (!rd_n && !cs_n) begin
                rd_len <= rd_len + 1;
                bus_in <= (rd_len >= 4) ? adc_res : JUNK;
            end
            if (!rd_q && rd_n) begin
                last_rd_len <= rd_len; rd_len <= 0; bus_in <= JUNK;
                raise_cnt <= 2; rd_rise_cyc <= cyc;
            end
            if (done) begin done_cnt <= done_cnt + 1; done_cyc <= cyc; end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] cmd, input logic ch, input logic [7:0] data);
        @(negedge clk);
        req_valid = 1'b1; req_cmd = cmd; req_chan = ch; req_wdata = data;
        @(negedge clk);
        req_valid = 1'b0; req_cmd = 2'b00;
    endtask

    task automatic wait_done(input int base);
        for (int i = 0; i < 2000; i++) begin
            @(negedge clk);
            if (done_cnt > base) break;
        end
        @(negedge clk);
    endtask

    task automatic run_op(input logic [1:0] cmd, input logic ch, input logic [7:0] data, input int dly);
        int base;
        next_adc = data; conv_delay = dly; base = done_cnt;
        issue(cmd, ch, data);
        wait_done(base);
        chk(done_cnt == base + 1, "R11 one done per request", done_cnt - base, 1);
    endtask

    initial begin
        int lat;
        int ops;
        int seen_busy;
        int base;
        ops = 0;
        // reset state
        repeat (3) @(negedge clk);
        chk(cs_n && wr_n && rd_n, "R10 strobes idle in reset", {cs_n, wr_n, rd_n}, 7);
        chk(!bus_oe, "R9 bus released in reset", bus_oe, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R10 ready after reset", req_ready, 1);
        chk(!done && !timeout_err, "R11 no done after reset", {done, timeout_err}, 0);

        // table walk
        for (int v = 0; v < NV; v++) begin
            run_op(VEC[v].cmd, VEC[v].ch, VEC[v].data, int'(VEC[v].dly));
            ops++;
            lat = done_cyc - wr_rise_cyc;
            case (VEC[v].cmd)
                2'd1: begin
                    chk(last_wr_len == WR_CYC, "R2 convert write width", last_wr_len, WR_CYC);
                    chk(!last_wr_dac && last_wr_chan == VEC[v].ch, "R3 convert selects",
                        {last_wr_dac, last_wr_chan}, {1'b0, VEC[v].ch});
                    chk(!timeout_err, "R3 no error", timeout_err, 0);
                    chk(lat >= int'(VEC[v].dly), "R3 done after INT", lat, int'(VEC[v].dly));
                end
                2'd2: begin
                    chk(rdata == VEC[v].data, "R6 read data", rdata, VEC[v].data);
                    chk(last_rd_len == RD_CYC, "R6 read strobe width", last_rd_len, RD_CYC);
                    chk(done_cyc - rd_rise_cyc >= REL_CYC, "R6 bus release wait",
                        done_cyc - rd_rise_cyc, REL_CYC);
                end
                default: begin
                    chk(dac_val[VEC[v].ch] == VEC[v].data, "R7 DAC code", dac_val[VEC[v].ch], VEC[v].data);
                    chk(last_wr_len == WR_CYC, "R2 DAC write width", last_wr_len, WR_CYC);
                    chk(last_setup >= SETUP_CYC, "R7 data setup", last_setup, SETUP_CYC);
                    chk(hold_cnt >= HOLD_CYC, "R7 data hold", hold_cnt, HOLD_CYC);
                    chk(lat >= SETTLE_CYC && lat <= SETTLE_CYC + HOLD_CYC + 2, "R8 settle wait", lat, SETTLE_CYC);
                end
            endcase
        end

        // busy requests ignored
        base = done_cnt; seen_busy = 0;
        next_adc = 8'h66; conv_delay = 100;
        issue(2'd1, 1'b1, 8'h00);
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            req_valid = 1'b1; req_cmd = 2'b11; req_chan = 1'b0; req_wdata = 8'hEE;
            if (!req_ready) seen_busy++;
        end
        req_valid = 1'b0; req_cmd = 2'b00;
        wait_done(base); ops++;
        chk(seen_busy == 10, "R10 ready low while busy", seen_busy, 10);
        chk(dac_val[0] == 8'h81, "R10 busy write ignored", dac_val[0], 8'h81);
        chk(dac_writes == 2, "R10 no extra DAC load", dac_writes, 2);

        // stale INT from unread conversion
        run_op(2'd1, 1'b0, 8'hC5, 30); ops++;
        run_op(2'd1, 1'b0, 8'h4D, 40); ops++;
        lat = done_cyc - wr_rise_cyc;
        chk(lat >= 39, "R4 stale INT ignored", lat, 40);
        run_op(2'd2, 1'b0, 8'h00, 0); ops++;
        chk(rdata == 8'h4D, "R4 fresh result read", rdata, 8'h4D);

        // timeout
        run_op(2'd1, 1'b1, 8'h00, 0); ops++;
        lat = done_cyc - wr_rise_cyc;
        chk(timeout_err == 1'b1, "R5 timeout flag", timeout_err, 1);
        chk(lat >= TO_CYC - 2 && lat <= TO_CYC + 4, "R5 timeout latency", lat, TO_CYC);

        // no-op command ignored, error flag persists
        base = done_cnt;
        issue(2'b00, 1'b0, 8'h00);
        repeat (5) @(negedge clk);
        chk(cs_n && req_ready && done_cnt == base, "R10 no-op ignored", {cs_n, req_ready}, 3);
        chk(timeout_err == 1'b1, "R5 flag held while idle", timeout_err, 1);

        run_op(2'd2, 1'b0, 8'h00, 0); ops++;
        chk(timeout_err == 1'b0, "R5 flag cleared by next request", timeout_err, 0);
        chk(rdata == 8'h4D, "R6 result kept after timeout", rdata, 8'h4D);

        chk(done_cnt == ops, "R11 total done pulses", done_cnt, ops);
        chk(oe_viol == 0, "R9 no drive during read", oe_viol, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog: actual %0d cycles expected completion", 150000);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule